// File: doc/BRIEF.md
# Aperture Page Remapping Table

The block translates bus-master addresses that fall inside a fixed aperture window into physical addresses, one 4 KiB page at a time. Every page of the window has one entry in an on-chip table. An entry holds a valid flag and a physical frame number. A lookup port compares an incoming address against the window, selects the entry for its page, and returns either a translated address or an invalid-access indication. The lookup is purely combinational.

Software programs the table through a small register port with three 32-bit registers. A control register holds the global translation enable. A pointer register holds the aperture address of the page to access. A data register gives indirect access to the entry that the pointer selects. To program an entry, software first writes the pointer and then writes or reads the data register. Reading the control register back returns the current enable value, so software can use that read to confirm that its earlier writes have landed.

Top module: `aprt_remap`

## Requirements
- R1: After reset, translation is disabled, the pointer register (offset 0x4) reads as the aperture base, and every entry is invalid, so reading offset 0x8 returns 0.
- R2: A write to offset 0x0 sets the enable from data bit 0 and ignores the other bits. A read of offset 0x0 returns the enable in bit 0, with bits 31:1 zero.
- R3: A write to offset 0x4 latches the full 32-bit data as the pointer, and a read of offset 0x4 returns that value.
- R4: When the pointer is page-aligned and inside the window, a write to offset 0x8 stores bit 31 as the valid flag and bits 30:12 as the frame number in the entry for that page. A read of offset 0x8 returns {valid, frame, 12'h000}.
- R5: When the pointer lies outside the window or is not 4 KiB-aligned, a write to offset 0x8 changes no entry, and a read of offset 0x8 returns 0.
- R6: When translation is enabled and the addressed entry is valid, the lookup asserts the hit output, clears the fault output, and returns {1'b0, frame, addr[11:0]}.
- R7: While translation is disabled, every lookup inside the window asserts the fault output with a physical output of 0, whatever the table contents.
- R8: A lookup inside the window that selects an entry whose valid flag is clear asserts the fault output, and the physical output stays 0. Writing an all-zero word to an entry makes it invalid.
- R9: The window runs from the base up to, but not including, base + PAGES*4096. A lookup outside the window asserts neither hit nor fault and returns 0. The last page of the window is translated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset (0x0 control, 0x4 pointer, 0x8 data) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| lk_addr | input | 32 | Address to translate |
| lk_phys | output | 32 | Translated physical address, 0 unless lk_hit |
| lk_hit | output | 1 | Translation succeeded |
| lk_fault | output | 1 | Invalid access inside the window |

## Verification
The hardest case to reach is a data-register write while the pointer is invalid. The rejected write must leave the table untouched, but the data port cannot show that, because a read through an invalid pointer always returns zero. The bench therefore writes through a misaligned pointer and through pointers just past the end of the window and one page below the base. It then moves the pointer back to a programmed page and confirms, both by read-back and by a lookup, that the old entry survived. The window edges are also driven from the lookup side: the last byte of the last page and the first byte past the end.

// File: rtl/aprt_pkg.sv
// Package: shared constants and the stored entry format of the remapping table.
package aprt_pkg;
    localparam int PG_SHIFT = 12;
    localparam int FRAME_W  = 31 - PG_SHIFT;     // frame field occupies bits 30:12
    localparam logic [3:0] OFF_CTRL = 4'h0;
    localparam logic [3:0] OFF_PTR  = 4'h4;
    localparam logic [3:0] OFF_DATA = 4'h8;

    typedef struct packed {
        logic               vld;
        logic [FRAME_W-1:0] frame;
    } ent_t;
endpackage

// File: rtl/aprt_regs.sv
// Module: register file. Holds the translation enable and the pointer, decodes
// writes into table updates, and muxes read data.
// Assumes APER_BASE is page-aligned and that the window does not wrap past 2^32.
module aprt_regs
    import aprt_pkg::*;
#(
    parameter logic [31:0] APER_BASE = 32'h5800_0000,
    parameter int          PAGES     = 16,
    localparam int         IDX_W     = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [3:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  ent_t             tbl_rent,
    output logic [IDX_W-1:0] tbl_idx,
    output logic             tbl_we,
    output ent_t             tbl_went,
    output logic             xl_en
);
    localparam logic [31:0] APER_END = APER_BASE + PAGES * (1 << PG_SHIFT);

    logic [31:0] ptr_q;
    logic [31:0] ptr_off;
    logic        ptr_ok;

    // Update the enable and the pointer on register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xl_en <= 1'b0;
            ptr_q <= APER_BASE;
        end else if (reg_we) begin
            if (reg_addr == OFF_CTRL) xl_en <= reg_wdata[0];
            if (reg_addr == OFF_PTR)  ptr_q <= reg_wdata;
        end
    end

    // Qualify the pointer: inside the window and page-aligned.
    always_comb begin
        ptr_off = ptr_q - APER_BASE;
        ptr_ok  = (ptr_q >= APER_BASE) && (ptr_q < APER_END) &&
                  (ptr_q[PG_SHIFT-1:0] == '0);
        tbl_idx = ptr_off[PG_SHIFT +: IDX_W];
    end

    // Turn a data-register write into an entry update.
    always_comb begin
        tbl_we         = reg_we && (reg_addr == OFF_DATA) && ptr_ok;
        tbl_went.vld   = reg_wdata[31];
        tbl_went.frame = reg_wdata[30:PG_SHIFT];
    end

    // Select the read data for the addressed register.
    always_comb begin
        case (reg_addr)
            OFF_CTRL: reg_rdata = {31'b0, xl_en};
            OFF_PTR:  reg_rdata = ptr_q;
            OFF_DATA: reg_rdata = ptr_ok ? {tbl_rent.vld, tbl_rent.frame, {PG_SHIFT{1'b0}}} : 32'h0;
            default:  reg_rdata = 32'h0;
        endcase
    end
endmodule

// File: rtl/aprt_table.sv
// Module: entry array built from flops. One write port and two combinational
// read ports (register side and lookup side). Every entry is cleared on reset.
module aprt_table
    import aprt_pkg::*;
#(
    parameter int  PAGES = 16,
    localparam int IDX_W = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  ent_t             went,
    input  logic [IDX_W-1:0] ridx_a,
    output ent_t             rent_a,
    input  logic [IDX_W-1:0] ridx_b,
    output ent_t             rent_b
);
    ent_t ent_q [PAGES];

    // Clear all entries on reset; otherwise write the selected one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGES; i++) ent_q[i] <= '0;
        end else if (we) begin
            ent_q[widx] <= went;
        end
    end

    // Combinational reads; an index beyond PAGES returns an invalid entry.
    always_comb begin
        rent_a = (int'(ridx_a) < PAGES) ? ent_q[ridx_a] : '0;
        rent_b = (int'(ridx_b) < PAGES) ? ent_q[ridx_b] : '0;
    end
endmodule

// File: rtl/aprt_lookup.sv
// Module: combinational translator. Checks the window, forms the page index,
// and produces the physical address, a hit, or a fault.
// Assumes APER_BASE is page-aligned.
module aprt_lookup
    import aprt_pkg::*;
#(
    parameter logic [31:0] APER_BASE = 32'h5800_0000,
    parameter int          PAGES     = 16,
    localparam int         IDX_W     = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic [31:0]      lk_addr,
    input  logic             xl_en,
    output logic [IDX_W-1:0] lk_idx,
    input  ent_t             lk_ent,
    output logic [31:0]      lk_phys,
    output logic             lk_hit,
    output logic             lk_fault
);
    localparam logic [31:0] APER_END = APER_BASE + PAGES * (1 << PG_SHIFT);

    logic [31:0] off;
    logic        in_win;

    // Window test, indexing and result formation.
    always_comb begin
        off      = lk_addr - APER_BASE;
        in_win   = (lk_addr >= APER_BASE) && (lk_addr < APER_END);
        lk_idx   = off[PG_SHIFT +: IDX_W];
        lk_hit   = in_win && xl_en && lk_ent.vld;
        lk_fault = in_win && !lk_hit;
        lk_phys  = lk_hit ? {1'b0, lk_ent.frame, lk_addr[PG_SHIFT-1:0]} : 32'h0;
    end
endmodule

// File: rtl/aprt_remap.sv
// Module: top of the aperture page remapping table. Ties together the register
// file, the entry array and the lookup path. Register reads and lookups are
// combinational; writes take effect at the next rising clock edge.
module aprt_remap
    import aprt_pkg::*;
#(
    parameter logic [31:0] APER_BASE = 32'h5800_0000,
    parameter int          PAGES     = 16,
    localparam int         IDX_W     = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] lk_addr,
    output logic [31:0] lk_phys,
    output logic        lk_hit,
    output logic        lk_fault
);
    ent_t             reg_ent, lk_ent, w_ent;
    logic [IDX_W-1:0] reg_idx, lk_idx;
    logic             w_en, xl_en;

    aprt_regs #(.APER_BASE(APER_BASE), .PAGES(PAGES)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tbl_rent(reg_ent),
        .tbl_idx(reg_idx), .tbl_we(w_en), .tbl_went(w_ent), .xl_en(xl_en)
    );

    aprt_table #(.PAGES(PAGES)) u_tbl (
        .clk(clk), .rst_n(rst_n), .we(w_en), .widx(reg_idx), .went(w_ent),
        .ridx_a(reg_idx), .rent_a(reg_ent), .ridx_b(lk_idx), .rent_b(lk_ent)
    );

    aprt_lookup #(.APER_BASE(APER_BASE), .PAGES(PAGES)) u_lk (
        .lk_addr(lk_addr), .xl_en(xl_en), .lk_idx(lk_idx), .lk_ent(lk_ent),
        .lk_phys(lk_phys), .lk_hit(lk_hit), .lk_fault(lk_fault)
    );
endmodule

// File: rtl/aprt_remap_chk.sv
// Module: property checker for aprt_remap, attached by bind. It keeps its own
// copy of the pointer, built from port writes, to qualify data reads.
module aprt_remap_chk #(
    parameter logic [31:0] APER_BASE = 32'h5800_0000,
    parameter int          PAGES     = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [3:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic [31:0] lk_addr,
    input logic [31:0] lk_phys,
    input logic        lk_hit,
    input logic        lk_fault
);
    localparam logic [31:0] WEND = APER_BASE + PAGES * 4096;
    logic [31:0] shadow_ptr;
    logic        shadow_ok, lk_in;

    // Track the pointer as software writes it.
    always_ff @(posedge clk) begin
        if (!rst_n) shadow_ptr <= APER_BASE;
        else if (reg_we && reg_addr == 4'h4) shadow_ptr <= reg_wdata;
    end

    assign shadow_ok = (shadow_ptr >= APER_BASE) && (shadow_ptr < WEND) && (shadow_ptr[11:0] == 12'h0);
    assign lk_in     = (lk_addr >= APER_BASE) && (lk_addr < WEND);

    p_ctrl_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 4'h0) |-> (reg_rdata[31:1] == 31'h0));
    p_bad_ptr_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 4'h8 && !shadow_ok) |-> (reg_rdata == 32'h0));
    p_hit_format_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (!lk_fault && !lk_phys[31] && lk_phys[11:0] == lk_addr[11:0]));
    p_off_no_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 4'h0 && !reg_wdata[0]) |=> !lk_hit);
    p_no_phys_on_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_phys == 32'h0));
    p_outside_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_in |-> (!lk_hit && !lk_fault));
    p_inside_decided_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_in |-> (lk_hit != lk_fault));
endmodule

bind aprt_remap aprt_remap_chk #(.APER_BASE(APER_BASE), .PAGES(PAGES)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
    .lk_phys(lk_phys), .lk_hit(lk_hit), .lk_fault(lk_fault)
);

// File: tb/tb_aprt_remap.sv
`timescale 1ns/1ps
// Directed bench for aprt_remap: one task per scenario, each checking its results.
module tb_aprt_remap;
    localparam logic [31:0] BASE = 32'h5800_0000;
    localparam int          NPG  = 16;
    localparam logic [31:0] WEND = BASE + NPG * 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [31:0] lk_addr = 32'h0;
    logic [31:0] lk_phys;
    logic        lk_hit, lk_fault;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    aprt_remap #(.APER_BASE(BASE), .PAGES(NPG)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
        .lk_phys(lk_phys), .lk_hit(lk_hit), .lk_fault(lk_fault)
    );

    // Watchdog: an expired run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] off, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = off; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] off, output logic [31:0] d);
        @(negedge clk);
        reg_addr = off; #1;
        d = reg_rdata;
    endtask

    task automatic look(input logic [31:0] a, output logic [31:0] p, output logic h, output logic f);
        @(negedge clk);
        lk_addr = a; #1;
        p = lk_phys; h = lk_hit; f = lk_fault;
    endtask

    task automatic t_reset();
        logic [31:0] v, p; logic h, f;
        rd(4'h0, v); chk("R1 ctrl after reset", v, 32'h0);
        rd(4'h4, v); chk("R1 pointer after reset", v, BASE);
        rd(4'h8, v); chk("R1 entry after reset", v, 32'h0);
        look(BASE + 32'h10, p, h, f); chk("R1 lookup after reset", {p[29:0], h, f}, {30'h0, 1'b0, 1'b1});
    endtask

    task automatic t_config();
        logic [31:0] v, p; logic h, f;
        wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, v); chk("R2 ctrl read enabled", v, 32'h1);
        wr(4'h0, 32'hFFFF_FFFE); rd(4'h0, v); chk("R2 ctrl bit0 only", v, 32'h0);
        wr(4'h0, 32'h1);
        look(BASE + 32'h5000, p, h, f); chk("R8 empty entry faults", {p, h, f}, {32'h0, 1'b0, 1'b1});
    endtask

    task automatic t_pointer();
        logic [31:0] v;
        wr(4'h4, 32'hDEAD_BEEF); rd(4'h4, v); chk("R3 pointer readback", v, 32'hDEAD_BEEF);
    endtask

    task automatic t_program();
        logic [31:0] v, p; logic h, f;
        wr(4'h4, BASE + 32'h3000); wr(4'h8, 32'h8012_3FFF);
        rd(4'h8, v); chk("R4 entry readback", v, 32'h8012_3000);
        look(BASE + 32'h3ABC, p, h, f); chk("R6 translated", {p, h, f}, {32'h0012_3ABC, 1'b1, 1'b0});
        wr(4'h4, BASE + 32'h7000); wr(4'h8, 32'hFFFF_F000);
        look(BASE + 32'h7001, p, h, f); chk("R6 full frame", {p, h, f}, {32'h7FFF_F001, 1'b1, 1'b0});
    endtask

    task automatic t_bad_ptr();
        logic [31:0] v, p; logic h, f;
        wr(4'h4, BASE + 32'h3004); wr(4'h8, 32'h8055_5000);
        rd(4'h8, v); chk("R5 misaligned reads zero", v, 32'h0);
        wr(4'h4, WEND); wr(4'h8, 32'h8066_6000);
        rd(4'h8, v); chk("R5 past end reads zero", v, 32'h0);
        wr(4'h4, BASE - 32'h1000); wr(4'h8, 32'h8077_7000);
        rd(4'h8, v); chk("R5 below base reads zero", v, 32'h0);
        wr(4'h4, BASE + 32'h3000);
        rd(4'h8, v); chk("R5 entry kept", v, 32'h8012_3000);
        wr(4'h4, BASE);
        rd(4'h8, v); chk("R5 page0 untouched", v, 32'h0);
        look(BASE + 32'h3000, p, h, f); chk("R5 lookup unchanged", {p, h, f}, {32'h0012_3000, 1'b1, 1'b0});
    endtask

    task automatic t_window();
        logic [31:0] p; logic h, f;
        wr(4'h4, WEND - 32'h1000); wr(4'h8, 32'h8777_7000);
        look(WEND - 32'h1, p, h, f); chk("R9 last byte translated", {p, h, f}, {32'h0777_7FFF, 1'b1, 1'b0});
        look(WEND, p, h, f); chk("R9 end excluded", {p, h, f}, {32'h0, 1'b0, 1'b0});
        look(BASE - 32'h1, p, h, f); chk("R9 below base", {p, h, f}, {32'h0, 1'b0, 1'b0});
    endtask

    task automatic t_disable();
        logic [31:0] v, p; logic h, f;
        wr(4'h0, 32'h0);
        look(BASE + 32'h3000, p, h, f); chk("R7 disabled faults", {p, h, f}, {32'h0, 1'b0, 1'b1});
        look(WEND - 32'h4, p, h, f); chk("R7 disabled last page", {p, h, f}, {32'h0, 1'b0, 1'b1});
        wr(4'h4, BASE + 32'h3000); rd(4'h8, v); chk("R7 table kept while off", v, 32'h8012_3000);
        wr(4'h0, 32'h1);
        look(BASE + 32'h3000, p, h, f); chk("R7 re-enabled", {p, h, f}, {32'h0012_3000, 1'b1, 1'b0});
    endtask

    task automatic t_invalidate();
        logic [31:0] v, p; logic h, f;
        wr(4'h4, BASE + 32'h3000); wr(4'h8, 32'h0);
        rd(4'h8, v); chk("R8 cleared readback", v, 32'h0);
        look(BASE + 32'h3123, p, h, f); chk("R8 cleared faults", {p, h, f}, {32'h0, 1'b0, 1'b1});
        wr(4'h8, 32'h0012_3000);
        look(BASE + 32'h3123, p, h, f); chk("R8 frame without valid", {p, h, f}, {32'h0, 1'b0, 1'b1});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_config();
        t_pointer();
        t_program();
        t_bad_ptr();
        t_window();
        t_disable();
        t_invalidate();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule